// File: doc/BRIEF.md
# Manchester II Sync-Detecting Decoder

This block turns a Manchester II biphase line back into data. It samples the line on a decoder clock that runs at twelve times the bit rate. It looks for the three-bit-time sync pattern that opens a word, and from the order of the two sync halves it decides whether a command word or a data word follows. It then recovers sixteen data bits and an odd parity bit, realigning its bit timing on every mid-bit transition.

The recovered data bits leave serially on `ser_data`, each one marked by a single-cycle strobe on `shift_clk`, so an external shift register can collect the word. `valid_word` reports at the end of each reception whether the word arrived intact. The line can be driven as a complementary pair (`bip_one_in`/`bip_zero_in`) or as one level (`uni_in`). A decoder-only reset (`dec_rst`) and the master reset (`rst`) both abandon any reception in progress and send the block back to hunting for a sync.

Top module: `manch_rx`

## Requirements
- R1: The line level is (bip_one_in AND NOT bip_zero_in) OR (uni_in AND bip_zero_in). In bipolar use uni_in is held 0 and the pair is complementary. In unipolar use bip_one_in is held 0 and bip_zero_in is held 1. A data one is high in its first half and low in its second half.
- R2: A sync that is high for 18 samples and then low for 18 samples is a command sync and sets cmd_sync to 1. A sync that is low and then high is a data sync and sets cmd_sync to 0.
- R3: The first sync half is accepted at 17, 18 or 19 samples. A run of 16 or 20 samples is ignored: no strobe occurs and valid_word and cmd_sync keep their values.
- R4: Each accepted word gives exactly 16 one-cycle shift_clk strobes, MSB first. ser_data holds the bit while its strobe is high. The parity bit is not strobed.
- R5: At the end of a complete word, valid_word becomes 1 if the 17 bits (data plus parity) hold an odd number of ones, and 0 otherwise.
- R6: During a reception, valid_word keeps the value left by the previous reception until the new word ends.
- R7: A bit with no mid-bit transition, or a constant level longer than 26 samples during a reception, ends the reception. valid_word goes to 0, no further strobes follow, and the block hunts for the next sync.
- R8: Bit timing is realigned at each mid-bit transition, so words whose bit period is 11 or 13 samples still decode correctly.
- R9: dec_rst or rst clears valid_word, cmd_sync and shift_clk and aborts reception. A later word decodes normally.
- R10: After reset, valid_word, cmd_sync, shift_clk and ser_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder sample clock, 12 times the bit rate |
| rst | input | 1 | Master reset, synchronous, active high |
| dec_rst | input | 1 | Decoder reset, synchronous, active high |
| bip_one_in | input | 1 | Bipolar line, high-side input |
| bip_zero_in | input | 1 | Bipolar line, low-side input (held 1 for unipolar use) |
| uni_in | input | 1 | Single-ended line input (held 0 for bipolar use) |
| shift_clk | output | 1 | One-cycle strobe for each recovered data bit |
| ser_data | output | 1 | Recovered data bit, valid while shift_clk is high |
| cmd_sync | output | 1 | Type of the last accepted sync: 1 for command, 0 for data |
| valid_word | output | 1 | Result of the last finished reception |

## Verification
On every cycle the assertions check four things:
- each strobe lasts one cycle and only occurs while bits are being received;
- valid_word can rise only when a word finishes;
- the bit phase counter stays inside one bit period;
- a decoder reset always clears the flag and the strobe.

Other behaviours only show up in the bench's scenarios:
- the sync type and tolerance window;
- MSB-first order and the parity decision;
- the flag being held across a new reception;
- dropping a word on a missing transition or a held level;
- tracking of bit periods that are too long or too short.

// File: rtl/manch_rx_pkg.sv
package manch_rx_pkg;
  typedef enum logic [1:0] {
    RX_HUNT  = 2'd0,
    RX_SYNC2 = 2'd1,
    RX_BITS  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/manch_rx_front.sv
module manch_rx_front #(
  parameter int SPB = 12,
  parameter int TOL = 1,
  parameter int RW  = 5
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          bip_one,
  input  logic          bip_zero,
  input  logic          uni,
  output logic          ln,
  output logic          tr,
  output logic [RW-1:0] run,
  output logic          sync_hit,
  output logic          sync_cmd
);
  localparam int SYNC_LEN = 3 * SPB / 2;
  localparam logic [RW-1:0] R_MAX = RW'(2 * SPB + 2);
  localparam logic [RW-1:0] S_LO  = RW'(SYNC_LEN - TOL);
  localparam logic [RW-1:0] S_HI  = RW'(SYNC_LEN + TOL);

  logic lvl, s1, ln_d;

  // R1: merge the two input styles into one line level
  assign lvl = (bip_one & ~bip_zero) | (uni & bip_zero);

  always_ff @(posedge clk) begin
    if (clr) begin
      s1   <= 1'b0;
      ln   <= 1'b0;
      ln_d <= 1'b0;
      run  <= R_MAX;
    end else begin
      s1   <= lvl;
      ln   <= s1;
      ln_d <= ln;
      if (tr)
        run <= RW'(1);
      else if (run != R_MAX)
        run <= run + 1'b1;
    end
  end

  assign tr       = ln ^ ln_d;
  assign sync_hit = tr && (run >= S_LO) && (run <= S_HI);
  assign sync_cmd = ln_d;
endmodule

// File: rtl/manch_rx_core.sv
module manch_rx_core
  import manch_rx_pkg::*;
#(
  parameter int SPB   = 12,
  parameter int NBITS = 16,
  parameter int RW    = 5
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          ln,
  input  logic          tr,
  input  logic [RW-1:0] run,
  input  logic          sync_hit,
  input  logic          sync_cmd,
  output logic          shift_clk,
  output logic          ser_data,
  output logic          cmd_sync,
  output logic          valid_word
);
  localparam int HALF     = SPB / 2;
  localparam int SYNC_LEN = 3 * SPB / 2;
  localparam int PW       = $clog2(SPB);
  localparam int CW       = $clog2(SYNC_LEN);
  localparam int NW       = $clog2(NBITS + 1);
  localparam logic [RW-1:0] R_MAX  = RW'(2 * SPB + 2);
  localparam logic [PW-1:0] P_Q1   = PW'(HALF / 2);
  localparam logic [PW-1:0] P_Q3   = PW'(HALF + HALF / 2);
  localparam logic [PW-1:0] P_END  = PW'(SPB - 1);
  localparam logic [PW-1:0] W_LO   = PW'(HALF - 2);
  localparam logic [PW-1:0] W_HI   = PW'(HALF + 2);
  localparam logic [PW-1:0] P_RE   = PW'(HALF + 1);
  localparam logic [CW-1:0] C_MID  = CW'(SYNC_LEN / 2);
  localparam logic [CW-1:0] C_LAST = CW'(SYNC_LEN - 1);
  localparam logic [NW-1:0] NB_LAST = NW'(NBITS);

  rx_state_e     st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] ph;
  logic [NW-1:0] nb;
  logic          a, b, par, pend;

  always_ff @(posedge clk) begin
    if (clr) begin
      st <= RX_HUNT;  cnt <= '0;  ph <= '0;  nb <= '0;
      a <= 1'b0;  b <= 1'b0;  par <= 1'b0;  pend <= 1'b0;
      shift_clk <= 1'b0;  ser_data <= 1'b0;
      cmd_sync <= 1'b0;   valid_word <= 1'b0;
    end else begin
      shift_clk <= 1'b0;
      unique case (st)
        RX_HUNT: begin
          if (sync_hit) begin
            st   <= RX_SYNC2;
            cnt  <= CW'(1);
            pend <= sync_cmd;
          end
        end
        RX_SYNC2: begin
          cnt <= cnt + 1'b1;
          if (cnt == C_LAST) begin
            st       <= RX_BITS;
            ph       <= '0;
            nb       <= '0;
            par      <= 1'b0;
            cmd_sync <= pend;
          end
          if ((cnt == C_MID && ln == pend) || run == R_MAX) begin
            st         <= RX_HUNT;
            valid_word <= 1'b0;
          end
        end
        RX_BITS: begin
          ph <= ph + 1'b1;
          if (tr && ph >= W_LO && ph <= W_HI)
            ph <= P_RE;
          if (ph == P_Q1) a <= ln;
          if (ph == P_Q3) b <= ln;
          if (ph == P_END) begin
            ph <= '0;
            if (a == b) begin
              st         <= RX_HUNT;
              valid_word <= 1'b0;
            end else if (nb == NB_LAST) begin
              st         <= RX_HUNT;
              valid_word <= par ^ a;
            end else begin
              par       <= par ^ a;
              nb        <= nb + 1'b1;
              shift_clk <= 1'b1;
              ser_data  <= a;
            end
          end
          if (run == R_MAX) begin
            st         <= RX_HUNT;
            valid_word <= 1'b0;
          end
        end
        default: st <= RX_HUNT;
      endcase
    end
  end

  // R4
  sclk_pulse_chk: assert property (@(posedge clk) disable iff (clr)
    shift_clk |=> !shift_clk);

  // R4
  sclk_in_rx_chk: assert property (@(posedge clk) disable iff (clr)
    shift_clk |-> (st == RX_BITS));

  // R6
  valid_rise_chk: assert property (@(posedge clk) disable iff (clr)
    $rose(valid_word) |-> ($past(st) == RX_BITS && st == RX_HUNT));

  // R8
  phase_range_chk: assert property (@(posedge clk) disable iff (clr)
    (st == RX_BITS) |-> (ph <= P_END));
endmodule

// File: rtl/manch_rx.sv
module manch_rx #(
  parameter int SPB   = 12,
  parameter int TOL   = 1,
  parameter int NBITS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic dec_rst,
  input  logic bip_one_in,
  input  logic bip_zero_in,
  input  logic uni_in,
  output logic shift_clk,
  output logic ser_data,
  output logic cmd_sync,
  output logic valid_word
);
  localparam int RW = $clog2(2 * SPB + 3);

  logic          clr, ln, tr, sync_hit, sync_cmd;
  logic [RW-1:0] run;

  assign clr = rst | dec_rst;

  manch_rx_front #(.SPB(SPB), .TOL(TOL), .RW(RW)) u_front (
    .clk(clk), .clr(clr), .bip_one(bip_one_in), .bip_zero(bip_zero_in),
    .uni(uni_in), .ln(ln), .tr(tr), .run(run),
    .sync_hit(sync_hit), .sync_cmd(sync_cmd)
  );

  manch_rx_core #(.SPB(SPB), .NBITS(NBITS), .RW(RW)) u_core (
    .clk(clk), .clr(clr), .ln(ln), .tr(tr), .run(run),
    .sync_hit(sync_hit), .sync_cmd(sync_cmd),
    .shift_clk(shift_clk), .ser_data(ser_data),
    .cmd_sync(cmd_sync), .valid_word(valid_word)
  );

  // R9
  decrst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    dec_rst |=> (!valid_word && !shift_clk && !cmd_sync));
endmodule

// File: tb/sim_manch_rx.sv
module sim_manch_rx;
  logic clk = 1'b0;
  logic rst = 1'b1, dec_rst = 1'b0;
  logic bip_one_in = 1'b0, bip_zero_in = 1'b0, uni_in = 1'b0;
  logic shift_clk, ser_data, cmd_sync, valid_word;

  int checks = 0, errors = 0;
  int nstb = 0;
  logic [15:0] rxw = '0;
  bit cur = 1'b0;
  bit uni_mode = 1'b0;

  always #4 clk = ~clk;

  manch_rx u0 (
    .clk(clk), .rst(rst), .dec_rst(dec_rst),
    .bip_one_in(bip_one_in), .bip_zero_in(bip_zero_in), .uni_in(uni_in),
    .shift_clk(shift_clk), .ser_data(ser_data),
    .cmd_sync(cmd_sync), .valid_word(valid_word)
  );

  always @(negedge clk) begin
    if (shift_clk) begin
      rxw  <= {rxw[14:0], ser_data};
      nstb <= nstb + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic apply();
    if (uni_mode) begin
      bip_one_in = 1'b0; bip_zero_in = 1'b1; uni_in = cur;
    end else begin
      bip_one_in = cur; bip_zero_in = ~cur; uni_in = 1'b0;
    end
  endtask

  task automatic drive(input bit lv, input int n);
    cur = lv;
    apply();
    repeat (n) @(negedge clk);
  endtask

  // errbit: bit held without a mid transition; rstbit: reset before that bit
  task automatic send_word(input bit cmd, input logic [15:0] d, input bit pgood,
                           input int h1, input int h2, input int s1,
                           input int errbit, input int rstbit, input bit rstm,
                           input bit probe);
    logic [16:0] bits;
    bit first;
    bits  = {d, pgood ? ~(^d) : (^d)};
    first = cmd;
    drive(~first, 30);
    drive(first, s1);
    drive(~first, 18);
    for (int i = 0; i < 17; i++) begin
      bit bv;
      bv = bits[16 - i];
      if (i == rstbit) begin
        if (rstm) rst = 1'b1; else dec_rst = 1'b1;
        drive(cur, 1);
        rst = 1'b0; dec_rst = 1'b0;
        break;
      end
      if (i == errbit) begin
        drive(bv, 30);
        break;
      end
      if (probe && i == 8) chk("R6 valid held during reception", valid_word, 1);
      drive(bv, h1);
      drive(~bv, h2);
    end
    drive(cur, 40);
  endtask

  task automatic sync_only(input bit first, input int len);
    drive(~first, 30);
    drive(first, len);
    drive(~first, 40);
  endtask

  task automatic good_word(input string tag, input bit cmd, input logic [15:0] d,
                           input int h1, input int h2, input int s1);
    int n0;
    n0 = nstb;
    send_word(cmd, d, 1'b1, h1, h2, s1, -1, -1, 1'b0, 1'b0);
    chk({tag, " valid"}, valid_word, 1);
    chk({tag, " cmd_sync"}, cmd_sync, cmd);
    chk({tag, " strobes"}, nstb - n0, 16);
    chk({tag, " data"}, rxw, d);
  endtask

  task automatic t_reset();
    chk("R10 valid after reset", valid_word, 0);
    chk("R10 cmd after reset", cmd_sync, 0);
    chk("R10 shift after reset", shift_clk, 0);
    chk("R10 data after reset", ser_data, 0);
  endtask

  task automatic t_sync_types();
    good_word("R2 R4 R5 command word", 1'b1, 16'hA5C3, 6, 6, 18);
    good_word("R2 R4 R5 data word", 1'b0, 16'h0001, 6, 6, 18);
  endtask

  task automatic t_parity();
    int n0;
    good_word("R5 setup", 1'b1, 16'h1234, 6, 6, 18);
    n0 = nstb;
    send_word(1'b1, 16'hFFFF, 1'b0, 6, 6, 18, -1, -1, 1'b0, 1'b1);
    chk("R5 bad parity valid", valid_word, 0);
    chk("R4 bad parity strobes", nstb - n0, 16);
    chk("R4 bad parity data", rxw, 16'hFFFF);
  endtask

  task automatic t_tolerance();
    int n0;
    good_word("R3 sync 17", 1'b1, 16'h8001, 6, 6, 17);
    good_word("R3 sync 19", 1'b0, 16'h4C2E, 6, 6, 19);
    n0 = nstb;
    sync_only(1'b1, 16);
    chk("R3 sync 16 strobes", nstb - n0, 0);
    chk("R3 sync 16 valid kept", valid_word, 1);
    chk("R3 sync 16 cmd kept", cmd_sync, 0);
    sync_only(1'b1, 20);
    chk("R3 sync 20 strobes", nstb - n0, 0);
    chk("R3 sync 20 valid kept", valid_word, 1);
  endtask

  task automatic t_unipolar();
    uni_mode = 1'b1;
    good_word("R1 unipolar data", 1'b0, 16'h7E81, 6, 6, 18);
    good_word("R1 unipolar command", 1'b1, 16'h0F0F, 6, 6, 18);
    uni_mode = 1'b0;
    good_word("R1 bipolar again", 1'b1, 16'hC003, 6, 6, 18);
  endtask

  task automatic t_realign();
    good_word("R8 period 13", 1'b1, 16'hB6D9, 7, 6, 18);
    good_word("R8 period 11", 1'b0, 16'h5AA5, 5, 6, 18);
  endtask

  task automatic t_drop();
    int n0;
    n0 = nstb;
    send_word(1'b1, 16'h3C5A, 1'b1, 6, 6, 18, 5, -1, 1'b0, 1'b0);
    chk("R7 missing transition valid", valid_word, 0);
    chk("R7 missing transition strobes", nstb - n0, 5);
    good_word("R7 recover", 1'b0, 16'h9999, 6, 6, 18);
    n0 = nstb;
    send_word(1'b0, 16'hE001, 1'b1, 6, 6, 18, 12, -1, 1'b0, 1'b0);
    chk("R7 held level valid", valid_word, 0);
    chk("R7 held level strobes", nstb - n0, 12);
  endtask

  task automatic t_resets();
    int n0;
    good_word("R9 setup", 1'b1, 16'h2468, 6, 6, 18);
    n0 = nstb;
    send_word(1'b1, 16'hFFFF, 1'b1, 6, 6, 18, -1, 9, 1'b0, 1'b0);
    chk("R9 decoder reset valid", valid_word, 0);
    chk("R9 decoder reset cmd", cmd_sync, 0);
    chk("R9 decoder reset strobes short", int'(nstb - n0 < 16), 1);
    good_word("R9 after decoder reset", 1'b1, 16'h1357, 6, 6, 18);
    n0 = nstb;
    send_word(1'b0, 16'hAAAA, 1'b1, 6, 6, 18, -1, 4, 1'b1, 1'b0);
    chk("R9 master reset valid", valid_word, 0);
    chk("R9 master reset strobes short", int'(nstb - n0 < 16), 1);
    good_word("R9 after master reset", 1'b0, 16'hFEDC, 6, 6, 18);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    apply();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sync_types();
    t_parity();
    t_tolerance();
    t_unipolar();
    t_realign();
    t_drop();
    t_resets();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule